// File: doc/BRIEF.md
# System Tick Down Counter

This block is a periodic down-counter for generating a regular operating-system tick. Software programs a reload value, selects which of two tick strobes advances the count (a processor-rate strobe or a slower external reference strobe) and turns the counter on. The count then steps down once per selected strobe. Each time it passes from one to zero it sets a sticky wrap flag and, when enabled, raises a one-cycle interrupt request. On the following strobe it starts again from the reload value.

Three registers sit behind a single-cycle register port: a control word (run, interrupt enable, strobe select, wrap flag), the reload value and the live count. Turning the counter on copies the reload value into the count, so the first period is complete. A write to the live count only clears it. It never starts the counter and never fixes the strobe choice. The next reload then comes either from turning the counter on or from a strobe while it runs.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A write to address 0 with bit 0 set, made while bit 0 was clear, loads the reload value into the count. The count reads that value in the next cycle, and no strobe is taken in that cycle.
- R3: While running, each selected strobe lowers the count by one, and a strobe at count zero reloads it. With reload value N the count repeats every N+1 strobes.
- R4: The wrap flag (control bit 16) is set when a strobe moves the count from 1 to 0. A read of address 0 with `reg_rd` high clears it, but a set in the same cycle takes priority.
- R5: With control bit 1 set, `irq` is high for exactly one cycle, the cycle after the strobe that moves the count from 1 to 0. With bit 1 clear, `irq` stays low.
- R6: Control bit 2 = 1 selects `cpu_tick` and bit 2 = 0 selects `ref_tick`. The strobe not selected has no effect on the count.
- R7: Any write to address 2 clears the count and the wrap flag. While bit 0 is clear, the count then stays at zero.
- R8: With a reload value of zero, a running counter stays at zero with no flag and no interrupt.
- R9: While control bit 0 is clear, the count holds its value whatever the strobes do.
- R10: Read data: address 0 gives run in bit 0, interrupt enable in bit 1, strobe select in bit 2 and the flag in bit 16. Address 1 gives the reload value, address 2 gives the count and address 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | Processor-rate count strobe |
| ref_tick | input | 1 | External reference count strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the flag on address 0) |
| reg_addr | input | 2 | Register select: 0 control, 1 reload, 2 count |
| reg_wdata | input | CNT_W (24) | Write data |
| reg_rdata | output | CNT_W (24) | Read data for `reg_addr`, combinational |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench sweeps reload values from 1 to 6 over three full periods each. It predicts the count and the interrupt arithmetically from the strobe index, so a counter that wraps to the reload value one strobe early or late, or that fires the interrupt on the reload strobe, shows up at once. A write to the count while the counter is stopped must leave it at zero under steady strobes. A design that restarted counting or loaded the reload value there would show a nonzero count. The strobe select is tested in both directions, including a select change in the same cycle as a strobe. The other cases are a zero reload value, which must never flag or interrupt, and the rule that a read clears the flag.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_CURR = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int RUN_BIT  = 0;
    localparam int IE_BIT   = 1;
    localparam int SRC_BIT  = 2;
    localparam int FLAG_BIT = 16;

    typedef struct packed {
        logic run;
        logic ie;
        logic src;
    } ctrl_t;

endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             start_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = 1'b0;
        if (wr && sel == SEL_CTRL) begin
            st_d.ctrl.run = wdata[RUN_BIT];
            st_d.ctrl.ie  = wdata[IE_BIT];
            st_d.ctrl.src = wdata[SRC_BIT];
            start_o       = wdata[RUN_BIT] && !st_q.ctrl.run;
        end
        if (wr && sel == SEL_LOAD) begin
            st_d.reload = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o   = st_q.ctrl;
    assign reload_o = st_q.reload;

endmodule

// File: rtl/tick_source_mux.sv
module tick_source_mux
    import tick_timer_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  cpu_tick,
    input  logic  ref_tick,
    output logic  tick_o
);

    always_comb begin
        tick_o = 1'b0;
        if (ctrl.run) begin
            tick_o = ctrl.src ? cpu_tick : ref_tick;
        end
    end

endmodule

// File: rtl/tick_down_core.sv
module tick_down_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clear,
    input  logic             tick,
    input  logic             ie,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             flag;
        logic             irq;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        wrap_hit;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        wrap_hit = 1'b0;
        if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        if (clear) begin
            st_d.count = CNT_ZERO;
            st_d.flag  = 1'b0;
        end else if (start) begin
            st_d.count = reload;
        end else if (tick) begin
            if (st_q.count == CNT_ZERO) begin
                st_d.count = reload;
            end else begin
                st_d.count = st_q.count - CNT_ONE;
                wrap_hit   = (st_q.count == CNT_ONE);
            end
        end
        if (wrap_hit) begin
            st_d.flag = 1'b1;
            st_d.irq  = ie;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign flag_o  = st_q.flag;
    assign irq_o   = st_q.irq;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_tick,
    input  logic             ref_tick,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);

    reg_sel_e         sel;
    ctrl_t            cfg_ctrl;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] count_w;
    logic             start_w;
    logic             tick_w;
    logic             flag_w;
    logic             en_w;
    logic             cur_wr;
    logic             ctrl_rd;

    assign sel     = reg_sel_e'(reg_addr);
    assign cur_wr  = reg_wr && (sel == SEL_CURR);
    assign ctrl_rd = reg_rd && (sel == SEL_CTRL);
    assign en_w    = cfg_ctrl.run;

    tick_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .sel      (sel),
        .wdata    (reg_wdata),
        .ctrl_o   (cfg_ctrl),
        .reload_o (reload_w),
        .start_o  (start_w)
    );

    tick_source_mux u_mux (
        .ctrl     (cfg_ctrl),
        .cpu_tick (cpu_tick),
        .ref_tick (ref_tick),
        .tick_o   (tick_w)
    );

    tick_down_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .clear    (cur_wr),
        .tick     (tick_w),
        .ie       (cfg_ctrl.ie),
        .flag_clr (ctrl_rd),
        .reload   (reload_w),
        .count_o  (count_w),
        .flag_o   (flag_w),
        .irq_o    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                reg_rdata[RUN_BIT]  = cfg_ctrl.run;
                reg_rdata[IE_BIT]   = cfg_ctrl.ie;
                reg_rdata[SRC_BIT]  = cfg_ctrl.src;
                reg_rdata[FLAG_BIT] = flag_w;
            end
            SEL_LOAD: reg_rdata = reload_w;
            SEL_CURR: reg_rdata = count_w;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             en,
    input logic             flag,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload
);

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (count == reload));

    p_irq_has_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_cur_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=> (count == '0 && !flag));

    p_zero_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == '0 && count == '0) |=> (count == '0));

    p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reg_wr) |=> $stable(count));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .en       (en_w),
    .flag     (flag_w),
    .irq      (irq),
    .count    (count_w),
    .reload   (reload_w)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;

    localparam int CNT_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cpu_tick = 1'b0;
    logic             ref_tick = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata;
    logic             irq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tick_timer #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .ref_tick(ref_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic ctrl_read_pulse();
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 2'd0;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [CNT_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] v;
        logic [CNT_W-1:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            check("R1 reset read", 32'(v), 32'd0);
        end
        check("R1 reset irq", 32'(irq), 32'd0);

        // R3 / R5 / R2 / R4: period sweep on the processor strobe
        @(negedge clk); cpu_tick = 1'b1; ref_tick = 1'b0;
        for (int r = 1; r <= 6; r++) begin
            reg_write(2'd0, 24'h4);
            reg_write(2'd1, CNT_W'(r));
            reg_write(2'd0, 24'h7);
            peek(2'd2, v);
            check("R2 load on start", 32'(v), 32'(r));
            for (int k = 1; k <= 3 * (r + 1); k++) begin
                step();
                peek(2'd2, v);
                check("R3 count", 32'(v), 32'(r - (k % (r + 1))));
                check("R5 irq pulse", 32'(irq), 32'((k % (r + 1)) == r));
                if (k == r) begin
                    peek(2'd0, v);
                    check("R4 flag set", 32'(v[16]), 32'd1);
                end
            end
        end

        // R4: read clears the flag (counter stopped so no new set)
        reg_write(2'd0, 24'h4);
        peek(2'd0, v);
        check("R4 flag before read", 32'(v[16]), 32'd1);
        ctrl_read_pulse();
        peek(2'd0, v);
        check("R4 flag cleared by read", 32'(v[16]), 32'd0);

        // R6: strobe select
        reg_write(2'd1, 24'd8);
        reg_write(2'd0, 24'h3);
        for (int k = 0; k < 4; k++) step();
        peek(2'd2, v);
        check("R6 cpu_tick ignored on ref select", 32'(v), 32'd8);
        @(negedge clk); cpu_tick = 1'b0; ref_tick = 1'b1;
        for (int k = 0; k < 3; k++) step();
        peek(2'd2, v);
        check("R6 ref_tick counts", 32'(v), 32'd5);
        reg_write(2'd0, 24'h7);
        peek(2'd2, v);
        check("R6 strobe on select edge uses old select", 32'(v), 32'd4);
        for (int k = 0; k < 3; k++) step();
        peek(2'd2, v);
        check("R6 ref_tick ignored on cpu select", 32'(v), 32'd4);
        @(negedge clk); cpu_tick = 1'b1; ref_tick = 1'b0;

        // R5: no interrupt with enable bit clear
        reg_write(2'd0, 24'h4);
        reg_write(2'd1, 24'd2);
        reg_write(2'd0, 24'h5);
        for (int k = 1; k <= 6; k++) begin
            step();
            check("R5 irq held low", 32'(irq), 32'd0);
            peek(2'd2, v);
            check("R3 count ie off", 32'(v), 32'(2 - (k % 3)));
        end
        peek(2'd0, v);
        check("R4 flag without irq", 32'(v[16]), 32'd1);

        // R7: count write while running
        reg_write(2'd2, 24'd5);
        peek(2'd2, v);
        check("R7 count cleared", 32'(v), 32'd0);
        peek(2'd0, v);
        check("R7 flag cleared", 32'(v[16]), 32'd0);
        step();
        peek(2'd2, v);
        check("R3 reload from zero", 32'(v), 32'd2);
        check("R5 no irq on reload", 32'(irq), 32'd0);

        // R9: stopped counter holds
        reg_write(2'd0, 24'h4);
        peek(2'd2, keep);
        for (int k = 0; k < 5; k++) step();
        peek(2'd2, v);
        check("R9 hold while stopped", 32'(v), 32'(keep));

        // R7: count write while stopped does not start
        reg_write(2'd2, 24'd9);
        for (int k = 0; k < 5; k++) begin
            step();
            peek(2'd2, v);
            check("R7 stays zero while stopped", 32'(v), 32'd0);
            check("R7 no irq while stopped", 32'(irq), 32'd0);
        end
        reg_write(2'd0, 24'h7);
        peek(2'd2, v);
        check("R2 start after count write", 32'(v), 32'd2);

        // R8: zero reload
        reg_write(2'd0, 24'h4);
        ctrl_read_pulse();
        reg_write(2'd1, 24'd0);
        reg_write(2'd0, 24'h7);
        for (int k = 0; k < 8; k++) begin
            step();
            peek(2'd2, v);
            check("R8 stays zero", 32'(v), 32'd0);
            check("R8 no irq", 32'(irq), 32'd0);
        end
        peek(2'd0, v);
        check("R8 no flag", 32'(v[16]), 32'd0);

        // R10: readback layout
        reg_write(2'd0, 24'h4);
        reg_write(2'd1, 24'hABCDE);
        peek(2'd1, v);
        check("R10 reload readback", 32'(v), 32'hABCDE);
        reg_write(2'd0, 24'h6);
        peek(2'd0, v);
        check("R10 control readback", 32'(v), 32'h6);
        peek(2'd3, v);
        check("R10 unused address", 32'(v), 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule